// File: doc/BRIEF.md
# Clock Generator Serial Control Slave

This block is a two-wire serial slave that lets a host program a small bank of 8-bit control registers inside a clock generator. It watches the bus clock and data lines, decodes start and stop conditions, compares a 7-bit device address and then runs one of two fixed byte sequences. There is no register pointer. A write always begins with two filler bytes that the slave acknowledges and throws away, and then fills registers from index 0 upwards. A read returns registers from index 0 upwards with no command byte.

Register 0 drives the clock generator's control pins:
- a tristate-all-outputs bit;
- a spread-spectrum enable, spread type and spread magnitude;
- a software frequency code, with a bit that chooses between that code and the hardware select pins.

Only the power-on reset loads register defaults. Bus start and stop conditions leave the registers unchanged.

Top module: `clkgen_ser_ctrl`

## Requirements
- R1: An address byte whose upper 7 bits equal DEV_ADDR is acknowledged, with R/W in bit 0 (0 = write, 1 = read). Any other address gets no acknowledge, and the slave leaves the bus alone until the next start condition.
- R2: In a write, the first two bytes after the address (command code, byte count) are acknowledged and change no register. Each following byte is acknowledged and stored in register 0, 1, 2 and so on, in that order.
- R3: In a read, the slave sends register 0, then 1, then 2 and so on, MSB first, for as long as the master acknowledges each byte.
- R4: Write bytes past the last register (index NUM_REGS and above) are acknowledged and discarded. Reads past the last register return 0xFF.
- R5: Registers are all 0 after the power-on reset and are reloaded by nothing else. Start and stop conditions keep their contents.
- R6: `fsel_o` equals register 0 bits 6:4 when register 0 bit 3 is 1, and equals `hw_fsel` otherwise.
- R7: Register 0 bit 7 drives `spread_narrow_o` (1 = ±0.5%, 0 = ±1.5%), bit 2 drives `spread_down_o` (1 = down, 0 = center), bit 1 drives `spread_en_o`, and bit 0 drives `outputs_off_o`.
- R8: After a master not-acknowledge in a read, the slave stops driving the data line until the next start condition.
- R9: A repeated start returns the byte sequencer to the address phase and releases the data line. A following read starts again at register 0.
- R10: The data line is only ever pulled low (open-drain enable), and the enable changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When 1, pull the data line low |
| hw_fsel | input | 3 | Frequency code from the hardware select pins |
| fsel_o | output | 3 | Effective frequency code |
| spread_narrow_o | output | 1 | Spread magnitude select |
| spread_down_o | output | 1 | Spread type select |
| spread_en_o | output | 1 | Spread-spectrum enable |
| outputs_off_o | output | 1 | Tristate all clock outputs |

## Verification
The assertions assume that the master is well behaved:
- it changes the data line only while the bus clock is low, except to form start and stop conditions;
- it never forms a start or stop condition while the slave is pulling the line low;
- it keeps each clock phase long enough to pass the two-flop synchronizer.

The bench master holds every half phase for six system clocks. It raises the line only after the slave's acknowledge window has closed. It builds the wired-AND line from its own drive and the slave's enable, so a driven-low slave always reads as low.

// File: rtl/clkgen_ser_pkg.sv
package clkgen_ser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } ser_state_t;
endpackage

// File: rtl/clkgen_ser_sync.sv
module clkgen_ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  // both lines idle high, so reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/clkgen_ser_bank.sv
module clkgen_ser_bank #(
  parameter int NUM_REGS = 8,
  parameter int IW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [7:0]    reg0
);
  logic [7:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we && (idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= 8'h00;
      else if (hit) mem[g] <= wdata;
    end
  end

  // indices past the bank read as all ones
  always_comb begin
    rdata = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IW'(i)) rdata = mem[i];
  end

  assign reg0 = mem[0];
endmodule

// File: rtl/clkgen_ser_engine.sv
module clkgen_ser_engine
  import clkgen_ser_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 8,
  parameter int         IW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic [7:0]    rdata,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [IW-1:0] reg_idx,
  output logic [7:0]    wdata
);
  localparam logic [IW-1:0] IDX_END = IW'(NUM_REGS);

  ser_state_t st, st_n;
  logic [3:0]    bcnt, bcnt_n;
  logic [7:0]    sh, sh_n;
  logic [1:0]    skip, skip_n;
  logic [IW-1:0] idx, idx_n;
  logic          oe, oe_n, rw, rw_n;

  always_comb begin
    st_n = st; bcnt_n = bcnt; sh_n = sh; skip_n = skip;
    idx_n = idx; oe_n = oe; rw_n = rw; reg_we = 1'b0;
    if (start_det) begin
      st_n = ST_ADDR; bcnt_n = '0; oe_n = 1'b0; idx_n = '0; skip_n = '0;
    end else if (stop_det) begin
      st_n = ST_IDLE; oe_n = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n = {sh[6:0], sda_s}; bcnt_n = bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            if (sh[7:1] == DEV_ADDR) begin
              oe_n = 1'b1; rw_n = sh[0]; st_n = ST_ADDR_ACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          bcnt_n = '0;
          if (rw) begin
            sh_n = rdata; oe_n = ~rdata[7]; st_n = ST_TX;
          end else begin
            oe_n = 1'b0; st_n = ST_RX;
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_n = {sh[6:0], sda_s}; bcnt_n = bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            oe_n = 1'b1; st_n = ST_RX_ACK;
            if (skip != 2'd2) skip_n = skip + 2'd1;
            else begin
              reg_we = 1'b1;
              if (idx != IDX_END) idx_n = idx + 1'b1;
            end
          end
        end
        ST_RX_ACK: if (scl_fall) begin
          oe_n = 1'b0; bcnt_n = '0; st_n = ST_RX;
        end
        ST_TX: if (scl_fall) begin
          if (bcnt == 4'd7) begin
            oe_n = 1'b0; st_n = ST_TX_ACK;
            if (idx != IDX_END) idx_n = idx + 1'b1;
          end else begin
            sh_n = {sh[6:0], 1'b0}; oe_n = ~sh[6]; bcnt_n = bcnt + 4'd1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_s) st_n = ST_IDLE;   // master NACK
          else if (scl_fall) begin
            sh_n = rdata; oe_n = ~rdata[7]; bcnt_n = '0; st_n = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bcnt <= '0; sh <= '0; skip <= '0;
      idx <= '0; oe <= 1'b0; rw <= 1'b0;
    end else begin
      st <= st_n; bcnt <= bcnt_n; sh <= sh_n; skip <= skip_n;
      idx <= idx_n; oe <= oe_n; rw <= rw_n;
    end
  end

  assign sda_oe  = oe;
  assign reg_idx = idx;
  assign wdata   = sh;
endmodule

// File: rtl/clkgen_ser_ctrl.sv
module clkgen_ser_ctrl #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] hw_fsel,
  output logic [2:0] fsel_o,
  output logic       spread_narrow_o,
  output logic       spread_down_o,
  output logic       spread_en_o,
  output logic       outputs_off_o
);
  localparam int IW = $clog2(NUM_REGS + 1);

  logic          rst_q1, rst_q2;
  logic          sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic          reg_we;
  logic [IW-1:0] reg_idx;
  logic [7:0]    wdata, rdata, reg0;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0; rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1; rst_q2 <= rst_q1;
    end
  end

  clkgen_ser_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_q2), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  clkgen_ser_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IW(IW)) u_eng (
    .clk(clk), .rst_n(rst_q2), .sda_s(sda_s), .start_det(start_det),
    .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .rdata(rdata), .sda_oe(sda_oe), .reg_we(reg_we), .reg_idx(reg_idx),
    .wdata(wdata));

  clkgen_ser_bank #(.NUM_REGS(NUM_REGS), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_q2), .we(reg_we), .idx(reg_idx),
    .wdata(wdata), .rdata(rdata), .reg0(reg0));

  assign fsel_o          = reg0[3] ? reg0[6:4] : hw_fsel;
  assign spread_narrow_o = reg0[7];
  assign spread_down_o   = reg0[2];
  assign spread_en_o     = reg0[1];
  assign outputs_off_o   = reg0[0];
endmodule

// File: rtl/clkgen_ser_chk.sv
module clkgen_ser_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_oe,
  input logic          start_det,
  input logic          reg_we,
  input logic [IW-1:0] reg_idx,
  input logic [7:0]    reg0
);
  always @(posedge clk)
    if (!rst_n) a_r5_reset_clears: assert (reg0 == 8'h00 && !sda_oe);

  a_r2_reg0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_idx == '0) |=> $stable(reg0));

  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  a_r10_drive_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !sda_i);

  a_r10_oe_scl_high_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i, 1) && $past(scl_i, 2) && $past(scl_i, 3) && $past(scl_i, 4))
      |-> $stable(sda_oe));
endmodule

bind clkgen_ser_ctrl clkgen_ser_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .start_det(start_det), .reg_we(reg_we), .reg_idx(reg_idx), .reg0(reg0));

// File: tb/sim_clkgen_ser_ctrl.sv
module sim_clkgen_ser_ctrl;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int NREG = 8;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst_n, scl_m, sda_m;
  logic [2:0] hw_fsel;
  wire  sda_oe, sda_line;
  wire  [2:0] fsel_o;
  wire  sp_nar, sp_down, sp_en, outs_off;
  int   checks = 0, errors = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] wbuf [16];

  assign sda_line = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  clkgen_ser_ctrl #(.DEV_ADDR(ADDR), .NUM_REGS(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .hw_fsel(hw_fsel), .fsel_o(fsel_o), .spread_narrow_o(sp_nar),
    .spread_down_o(sp_down), .spread_en_o(sp_en), .outputs_off_o(outs_off));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n = HOLD);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0;
    end
    sda_m = 1'b1; hold(); scl_m = 1'b1; hold(3);
    ack = ~sda_line; hold(3); scl_m = 1'b0; hold();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(); scl_m = 1'b1; hold(3); b = {b[6:0], sda_line}; hold(3); scl_m = 1'b0;
    end
    sda_m = ~mack; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    return (i < NREG) ? mdl[i] : 8'hFF;
  endfunction

  task automatic chk_decode;
    logic [2:0] ef;
    @(negedge clk);
    ef = mdl[0][3] ? mdl[0][6:4] : hw_fsel;
    chk(32'(fsel_o), 32'(ef), "R6 fsel");
    chk(32'({sp_nar, sp_down, sp_en, outs_off}),
        32'({mdl[0][7], mdl[0][2], mdl[0][1], mdl[0][0]}), "R7 decode");
  endtask

  task automatic do_write(input int n);
    logic a;
    bus_start;
    send_byte({ADDR, 1'b0}, a); chk(32'(a), 1, "R1 write addr ack");
    send_byte(8'($urandom), a); chk(32'(a), 1, "R2 command ack");
    send_byte(8'($urandom), a); chk(32'(a), 1, "R2 count ack");
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk(32'(a), 1, (i < NREG) ? "R2 data ack" : "R4 beyond ack");
      if (i < NREG) mdl[i] = wbuf[i];
    end
    bus_stop;
  endtask

  task automatic do_read(input int n);
    logic a;
    logic [7:0] b;
    bus_start;
    send_byte({ADDR, 1'b1}, a); chk(32'(a), 1, "R1 read addr ack");
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(32'(b), 32'(exp_rd(i)), (i < NREG) ? "R3 R5 read data" : "R4 beyond read");
    end
    bus_stop;
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'd1234));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; hw_fsel = 3'd6;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    hold(5); rst_n = 1'b1; hold(5);

    chk(32'(sda_oe), 0, "R5 reset no drive");
    chk_decode;
    do_read(10);

    wbuf[0] = 8'hB6; wbuf[1] = 8'h3C; wbuf[2] = 8'h77;
    do_write(3); chk_decode;
    hw_fsel = 3'd2; chk_decode;
    wbuf[0] = 8'h5B; do_write(1); chk_decode;
    chk(32'(fsel_o), 5, "R6 software code");

    // wrong address: no ack, following bytes ignored
    bus_start;
    send_byte({ADDR ^ 7'h01, 1'b0}, a); chk(32'(a), 0, "R1 wrong addr nack");
    send_byte(8'h00, a); chk(32'(a), 0, "R1 ignored after mismatch");
    send_byte(8'h00, a); send_byte(8'hFF, a); chk(32'(a), 0, "R1 still ignored");
    bus_stop;
    do_read(3);

    // repeated start into a read
    bus_start;
    send_byte({ADDR, 1'b0}, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h11, a); mdl[0] = 8'h11;
    bus_start;
    send_byte({ADDR, 1'b1}, a); chk(32'(a), 1, "R9 addr after restart");
    recv_byte(1'b1, b); chk(32'(b), 32'(mdl[0]), "R9 restart reads reg0");
    recv_byte(1'b0, b); chk(32'(b), 32'(mdl[1]), "R9 second byte");
    // after NACK the slave must not drive
    recv_byte(1'b0, b); chk(32'(b), 32'hFF, "R8 released after nack");
    bus_stop;
    chk_decode;

    for (int i = 0; i < 10; i++) wbuf[i] = 8'($urandom);
    do_write(10); do_read(10);

    for (int it = 0; it < 14; it++) begin
      int n;
      n = 1 + int'($urandom % 10);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      hw_fsel = 3'($urandom);
      do_write(n); chk_decode;
      do_read(1 + int'($urandom % 10));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule